// File: doc/BRIEF.md
# PAL Half-Rate Chroma Sample Generator

This block turns one picture element, given as luma and two signed colour-difference values, into 4-bit composite-video sample codes for a PAL colour signal. The clock runs at four times the colour subcarrier, so every subcarrier period has four samples, numbered by a phase counter from 0 to 3. The block also counts the line period, keeps track of whether the current line is odd or even, and flags the last clock of each line.

In full-rate mode a fresh sample level is produced every clock from the four quadrature positions of the carrier. In half-rate mode the block relies on the receiver's averaging of adjacent lines: it produces only two levels per carrier period and holds each for two clocks. On odd and even lines it uses different pairs, chosen so that the receiver's line sum and line difference still recover the intended U and V. The two levels of the current pair are also presented together as one byte, and two complementary select outputs mark which level of the pair is active. An external output stage can use these to switch between the two levels.

Top module: `pal_chroma_gen`

## Requirements
- R1: In full-rate mode (`half_mode`=0) on an odd line, the samples for phases 0,1,2,3 are Y+U, Y+V, Y−U, Y−V.
- R2: In full-rate mode on an even line, the samples for phases 0,1,2,3 are Y+U, Y−V, Y−U, Y+V.
- R3: In half-rate mode (`half_mode`=1), `sample_out` carries level A in phases 0 and 1 and level B in phases 2 and 3, and it does not change between phase 0 and phase 1.
- R4: Level A is Y+U+V on odd lines and Y+U−V on even lines. Level B is Y−U−V on odd lines and Y−U+V on even lines. `pair_out` always carries A in bits [7:4] and B in bits [3:0].
- R5: Every level is clamped to the range 0..15. A sum above 15 gives 15, and a sum below 0 gives 0.
- R6: A line lasts 1135 clocks, formed as five 227-clock ticks. `raster_tick` is high in the last clock of each line. On the following edge the phase returns to 0 and `line_odd` toggles. The first line after reset is odd (`line_odd`=1).
- R7: `sel_a` is high in phases 0 and 1 and low in phases 2 and 3. `sel_b` is always its complement.
- R8: `y_in`, `u_in` and `v_in` are captured only in phase 0. The values are held for phases 1 to 3, so changes to the inputs during those phases have no effect on the outputs until the next phase 0.
- R9: While `rst_n` is low, `sample_out`=0, `pair_out`=0, `sel_a`=1, `sel_b`=0, `line_odd`=1 and `raster_tick`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, four times the subcarrier |
| rst_n | input | 1 | Active-low synchronous reset |
| half_mode | input | 1 | 1 selects half-rate two-level output |
| y_in | input | 4 | Luma, unsigned |
| u_in | input | 5 | U colour difference, two's complement |
| v_in | input | 5 | V colour difference, two's complement |
| sample_out | output | 4 | Composite sample code |
| pair_out | output | 8 | Level A in the high nibble, level B in the low nibble |
| sel_a | output | 1 | High while level A is active |
| sel_b | output | 1 | Complement of sel_a |
| line_odd | output | 1 | Parity of the line the current sample belongs to |
| raster_tick | output | 1 | High in the last clock of each line |

## Verification
The phase, the parity and the captured inputs are all registered on the same edge. As a result, `sample_out`, `pair_out`, `sel_a`/`sel_b` and `line_odd` for the phase seen in clock k become valid one edge after clock k. The bench compares them 1 ns after that edge against a model that is advanced in the same step. `raster_tick` is decoded from the counters without a register, so the bench checks it before the edge of the clock it flags. Inputs change only between checks. The hold checks change the inputs in phases 1 to 3 and compare the outputs against the values captured in phase 0.

// File: rtl/pal_chroma_gen.sv
module pal_chroma_gen #(
  parameter int LVL_W          = 4,
  parameter int C_W            = 5,
  parameter int TICK_LEN       = 227,
  parameter int TICKS_PER_LINE = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  half_mode,
  input  logic [LVL_W-1:0]      y_in,
  input  logic signed [C_W-1:0] u_in,
  input  logic signed [C_W-1:0] v_in,
  output logic [LVL_W-1:0]      sample_out,
  output logic [2*LVL_W-1:0]    pair_out,
  output logic                  sel_a,
  output logic                  sel_b,
  output logic                  line_odd,
  output logic                  raster_tick
);
  localparam int SW   = ((LVL_W + 1 > C_W) ? LVL_W + 1 : C_W) + 2;
  localparam int MAXL = (1 << LVL_W) - 1;
  localparam int TW   = $clog2(TICK_LEN);
  localparam int KW   = $clog2(TICKS_PER_LINE);

  logic [TW-1:0] tick_cnt;
  logic [KW-1:0] sub_cnt;
  logic [1:0]    ph, ph_q;
  logic          par, par_q;
  logic          line_evt, tick_end;
  logic [LVL_W-1:0]      y_q;
  logic signed [C_W-1:0] u_q, v_q;

  assign tick_end = (tick_cnt == TW'(TICK_LEN - 1));
  assign line_evt = tick_end && (sub_cnt == KW'(TICKS_PER_LINE - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_cnt <= '0;
      sub_cnt  <= '0;
      ph       <= '0;
      par      <= 1'b1;
    end else begin
      tick_cnt <= tick_end ? '0 : tick_cnt + 1'b1;
      if (tick_end) sub_cnt <= line_evt ? '0 : sub_cnt + 1'b1;
      ph  <= line_evt ? 2'd0 : ph + 2'd1;
      if (line_evt) par <= ~par;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q  <= '0;
      par_q <= 1'b1;
      y_q   <= '0;
      u_q   <= '0;
      v_q   <= '0;
    end else begin
      ph_q  <= ph;
      par_q <= par;
      if (ph == 2'd0) begin
        y_q <= y_in;
        u_q <= u_in;
        v_q <= v_in;
      end
    end
  end

  function automatic logic [LVL_W-1:0] sat(input logic signed [SW-1:0] s);
    if (int'(s) < 0)         return '0;
    else if (int'(s) > MAXL) return LVL_W'(MAXL);
    else                     return LVL_W'(s);
  endfunction

  logic signed [SW-1:0] ys, us, vs, vl;
  logic [LVL_W-1:0] lvl_a, lvl_b, full_s;

  assign ys = SW'($signed({1'b0, y_q}));
  assign us = SW'(u_q);
  assign vs = SW'(v_q);
  assign vl = par_q ? vs : -vs;

  assign lvl_a = sat(ys + us + vl);
  assign lvl_b = sat(ys - us - vl);

  always_comb begin
    case (ph_q)
      2'd0:    full_s = sat(ys + us);
      2'd1:    full_s = sat(ys + vl);
      2'd2:    full_s = sat(ys - us);
      default: full_s = sat(ys - vl);
    endcase
  end

  assign sel_a       = ~ph_q[1];
  assign sel_b       = ph_q[1];
  assign pair_out    = {lvl_a, lvl_b};
  assign sample_out  = half_mode ? (sel_a ? lvl_a : lvl_b) : full_s;
  assign line_odd    = par_q;
  assign raster_tick = line_evt;

  p_phase_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    raster_tick |=> (ph == 2'd0) && (par != $past(par)));

  p_tick_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    raster_tick |=> !raster_tick);

  p_hold_inputs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != 2'd0) |=> $stable(y_q) && $stable(u_q) && $stable(v_q));

  p_square_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (half_mode && $past(half_mode) && ph_q == 2'd1) |-> $stable(sample_out));

  p_sel_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_a) |-> (ph_q == 2'd2));

  p_pair_nibble_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (half_mode && sel_a) |-> (sample_out == pair_out[2*LVL_W-1:LVL_W]));
endmodule

// File: tb/test_pal_chroma_gen.sv
module test_pal_chroma_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic half_mode = 1'b0;
  logic [3:0] y_in = '0;
  logic signed [4:0] u_in = '0, v_in = '0;
  logic [3:0] sample_out;
  logic [7:0] pair_out;
  logic sel_a, sel_b, line_odd, raster_tick;

  int errors = 0, checks = 0, kk = 0;
  int hy = 0, hu = 0, hv = 0;

  always #5 clk = ~clk;

  pal_chroma_gen i_pal_chroma_gen (
    .clk(clk), .rst_n(rst_n), .half_mode(half_mode), .y_in(y_in),
    .u_in(u_in), .v_in(v_in), .sample_out(sample_out), .pair_out(pair_out),
    .sel_a(sel_a), .sel_b(sel_b), .line_odd(line_odd), .raster_tick(raster_tick));

  localparam int NV = 6;
  localparam int VEC [NV][4] = '{
    '{0, 8, 3, 2}, '{0, 5, -4, 6}, '{1, 8, 2, 3},
    '{1, 7, -3, 1}, '{0, 10, -16, 15}, '{1, 2, 5, -5}};

  function automatic int sat(input int s);
    return (s < 0) ? 0 : (s > 15) ? 15 : s;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s kk=%0d actual=%0d expected=%0d", req, kk, act, exp);
    end
  endtask

  task automatic step(input string req);
    int ph, vl, a, b, full;
    bit odd;
    ph  = (kk % 1135) % 4;
    odd = ((kk / 1135) % 2) == 0;
    chk("R6 raster_tick", int'(raster_tick), int'((kk % 1135) == 1134));
    if (ph == 0) begin
      hy = int'(y_in); hu = int'(u_in); hv = int'(v_in);
    end
    vl = odd ? hv : -hv;
    a = sat(hy + hu + vl);
    b = sat(hy - hu - vl);
    case (ph)
      0: full = sat(hy + hu);
      1: full = sat(hy + vl);
      2: full = sat(hy - hu);
      default: full = sat(hy - vl);
    endcase
    @(posedge clk);
    #1;
    chk(req, int'(sample_out), half_mode ? ((ph < 2) ? a : b) : full);
    chk("R4 pair_out", int'(pair_out), a * 16 + b);
    chk("R7 sel_a", int'(sel_a), int'(ph < 2));
    chk("R7 sel_b", int'(sel_b), int'(ph >= 2));
    chk("R6 line_odd", int'(line_odd), int'(odd));
    kk++;
  endtask

  task automatic drive(input int h, input int y, input int u, input int v);
    half_mode = h[0];
    y_in = 4'(y);
    u_in = 5'(u);
    v_in = 5'(v);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    drive(0, 9, 3, 3);
    repeat (3) @(posedge clk);
    #1;
    chk("R9 sample_out", int'(sample_out), 0);
    chk("R9 pair_out", int'(pair_out), 0);
    chk("R9 sel_a", int'(sel_a), 1);
    chk("R9 sel_b", int'(sel_b), 0);
    chk("R9 line_odd", int'(line_odd), 1);
    chk("R9 raster_tick", int'(raster_tick), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);
      for (int j = 0; j < 8; j++) step(VEC[i][0] ? "R3 half sample" : "R1 full sample");
    end

    drive(1, 15, 15, 15);
    for (int j = 0; j < 4; j++) step("R5 saturate high");
    drive(0, 0, -16, -16);
    for (int j = 0; j < 4; j++) step("R5 saturate low");

    drive(0, 6, 2, 4);
    step("R8 capture");
    drive(0, 1, -7, 7);
    for (int j = 0; j < 3; j++) step("R8 hold");
    drive(1, 12, -2, 2);
    step("R8 capture half");
    drive(1, 0, 9, -9);
    for (int j = 0; j < 3; j++) step("R8 hold half");

    drive(0, 7, 3, 5);
    while (kk < 1135 + 16) step("R2 full across line");
    drive(1, 7, 3, 5);
    for (int j = 0; j < 8; j++) step("R4 half even line");
    drive(0, 4, -2, 3);
    while (kk < 2270 + 12) step("R6 second line boundary");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule